// File: doc/BRIEF.md
# SDRAM Command Front End with Bank Row Tracking

This block sits at the device side of a four-bank synchronous DRAM with a 16-bit data path. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines, the 12-bit address, the 2-bit bank select, the clock-enable and the two byte masks. It turns these into a command and keeps a table of which row, if any, is open in each bank.

The block reports each accepted command one cycle later. With the command it gives the target bank, the row (the new row for an activate, the bank's open row for an access) and the column, plus an auto-precharge flag. Address bit 10 is read according to the command: on an access it asks for the bank to close afterwards, and on a precharge it selects every bank. The byte masks are also read according to the command. On a write they blank the data bytes sampled at the same edge. In the read path they pass through a two-stage pipe, so they disable output bytes two edges later.

The clock-enable input suspends command acceptance from the cycle after it is sampled low. An auto-refresh encoding that arrives with clock-enable low starts self-refresh instead. Self-refresh then holds until clock-enable is seen high again.

Top module: `sdram_frontend`

## Requirements
- R1: With cs_n high, no command is accepted whatever the three strobes show: cmd_o reads 0 (no-operation) after that edge and no bank changes state.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows and is reported on cmd_o after the sampling edge: 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4), 001 auto-refresh (5) when cke is high, 111 no-operation (0). All other patterns report 0.
- R3: An activate sets bank_open_o[ba] and stores addr as that bank's row, and reports that row on row_o. A later read or write to the bank reports the stored row on row_o, ba on bank_o and addr[8:0] on col_o.
- R4: A read or write to a bank with no open row raises err_o for one cycle. It reports cmd_o = 0 and changes no bank state.
- R5: A read or write with addr[10] high sets auto_pre_o. The addressed bank's open flag is clear from that same edge onward.
- R6: A precharge with addr[10] high closes all four banks. With addr[10] low it closes only bank ba.
- R7: For an accepted write, wr_be_o equals ~dqm (bit 0 is the low byte), reported alongside the write. For every other command wr_be_o is 0.
- R8: rd_oe_o equals ~dqm as sampled two rising edges before the edge at which rd_oe_o is observed. After reset it is 0.
- R9: cke sampled low at an edge sets suspend_o. The command at the next edge is ignored (cmd_o = 0, banks unchanged). Acceptance resumes once cke has been sampled high again.
- R10: The auto-refresh encoding with cke low at the same edge reports cmd_o = 6 and sets sref_o. While sref_o is set, commands are ignored. sref_o clears at the first edge where cke is sampled high, and commands are accepted from the following edge.
- R11: After reset, all banks are closed, cmd_o is 0, every report output is 0, and sref_o and suspend_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Row/column address; bit 10 is the precharge qualifier |
| ba | input | 2 | Bank select |
| dqm | input | 2 | Byte masks, bit 0 low byte |
| cmd_o | output | 3 | Accepted command code |
| bank_o | output | 2 | Target bank |
| row_o | output | 12 | Row for activate or access |
| col_o | output | 9 | Column for access |
| auto_pre_o | output | 1 | Access requests close-after |
| wr_be_o | output | 2 | Write byte enables |
| rd_oe_o | output | 2 | Read output byte enables |
| err_o | output | 1 | Access to a closed bank |
| bank_open_o | output | 4 | Open flag per bank |
| sref_o | output | 1 | Self-refresh active |
| suspend_o | output | 1 | Next edge's command is suspended |

## Verification
The hardest states to reach from the ports are those where the clock-enable history overrides a legal command. One case is a command arriving in the cycle right after cke was sampled low. The other is a command issued during self-refresh, or on the exit edge itself. The stimulus builds these up step by step. It drives a suspend edge and then an activate to a closed bank, and confirms that the bank stays closed. It enters self-refresh with a refresh-and-cke-low edge, holds it while driving activates, and then checks that the exit edge accepts nothing while the edge after it does. Near-exhaustive strobe sweeps are run with chip select both high and low, each after a fresh activate, so that reads and writes always find a row open.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;

    localparam int NUM_BANKS   = 4;
    localparam int ROW_W       = 12;
    localparam int COL_W       = 9;
    localparam int BYTES       = 2;
    localparam int AP_BIT      = 10;
    localparam int RD_MASK_LAT = 2;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_SREF = 3'd6
    } cmd_e;

    function automatic cmd_e decode_strobes(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n,
                                            input logic cke);
        cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = cke ? CMD_REF : CMD_SREF;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_fe_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic accept,
    input  logic bank_hit,
    output cmd_e cmd_eff,
    output logic miss
);
    cmd_e raw;

    always_comb begin
        raw     = decode_strobes(cs_n, ras_n, cas_n, we_n, cke);
        miss    = accept && is_access(raw) && !bank_hit;
        cmd_eff = (!accept || miss) ? CMD_NOP : raw;
    end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
    import sdram_fe_pkg::*;
#(
    parameter int NB   = NUM_BANKS,
    parameter int RW   = ROW_W,
    parameter int APB  = AP_BIT,
    localparam int BAW = $clog2(NB)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cmd_e                   cmd,
    input  logic [BAW-1:0]         ba,
    input  logic [RW-1:0]          addr,
    output logic [NB-1:0]          open_flags,
    output logic [NB-1:0][RW-1:0]  rows
);
    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic sel;
        assign sel = (ba == BAW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_flags[g] <= 1'b0;
                rows[g]       <= '0;
            end else begin
                case (cmd)
                    CMD_ACT: if (sel) begin
                        open_flags[g] <= 1'b1;
                        rows[g]       <= addr;
                    end
                    CMD_PRE: if (sel || addr[APB]) open_flags[g] <= 1'b0;
                    CMD_RD, CMD_WR: if (sel && addr[APB]) open_flags[g] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdram_rd_mask_pipe.sv
module sdram_rd_mask_pipe
    import sdram_fe_pkg::*;
#(
    parameter int NBYTES = BYTES,
    parameter int LAT    = RD_MASK_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] mask,
    output logic [NBYTES-1:0] oe
);
    logic [LAT-1:0][NBYTES-1:0] stage;

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        stage[s] <= '0;
            else if (s == 0) stage[s] <= ~mask;
            else            stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
    end

    assign oe = stage[LAT-1];
endmodule

// File: rtl/sdram_frontend.sv
module sdram_frontend
    import sdram_fe_pkg::*;
#(
    parameter int NB   = NUM_BANKS,
    parameter int RW   = ROW_W,
    parameter int CW   = COL_W,
    parameter int NBY  = BYTES,
    localparam int BAW = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cke,
    input  logic           cs_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic [RW-1:0]  addr,
    input  logic [BAW-1:0] ba,
    input  logic [NBY-1:0] dqm,
    output logic [2:0]     cmd_o,
    output logic [BAW-1:0] bank_o,
    output logic [RW-1:0]  row_o,
    output logic [CW-1:0]  col_o,
    output logic           auto_pre_o,
    output logic [NBY-1:0] wr_be_o,
    output logic [NBY-1:0] rd_oe_o,
    output logic           err_o,
    output logic [NB-1:0]  bank_open_o,
    output logic           sref_o,
    output logic           suspend_o
);
    logic                 cke_q, sref_q, accept, miss;
    cmd_e                 cmd_eff;
    logic [NB-1:0][RW-1:0] rows;

    assign accept = cke_q && !sref_q;

    sdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .accept(accept), .bank_hit(bank_open_o[ba]),
        .cmd_eff(cmd_eff), .miss(miss)
    );

    sdram_bank_table #(.NB(NB), .RW(RW), .APB(AP_BIT)) u_banks (
        .clk(clk), .rst(rst), .cmd(cmd_eff), .ba(ba), .addr(addr),
        .open_flags(bank_open_o), .rows(rows)
    );

    sdram_rd_mask_pipe #(.NBYTES(NBY), .LAT(RD_MASK_LAT)) u_rdmask (
        .clk(clk), .rst(rst), .mask(dqm), .oe(rd_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q      <= 1'b1;
            sref_q     <= 1'b0;
            cmd_o      <= CMD_NOP;
            bank_o     <= '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            wr_be_o    <= '0;
            err_o      <= 1'b0;
        end else begin
            cke_q      <= cke;
            if (sref_q && cke)              sref_q <= 1'b0;
            else if (cmd_eff == CMD_SREF)   sref_q <= 1'b1;
            cmd_o      <= cmd_eff;
            err_o      <= miss;
            bank_o     <= (cmd_eff == CMD_NOP) ? '0 : ba;
            auto_pre_o <= is_access(cmd_eff) && addr[AP_BIT];
            col_o      <= is_access(cmd_eff) ? addr[CW-1:0] : '0;
            wr_be_o    <= (cmd_eff == CMD_WR) ? ~dqm : '0;
            if (cmd_eff == CMD_ACT)       row_o <= addr;
            else if (is_access(cmd_eff))  row_o <= rows[ba];
            else                          row_o <= '0;
        end
    end

    assign sref_o    = sref_q;
    assign suspend_o = !cke_q && !sref_q;
endmodule

// File: rtl/sdram_frontend_chk.sv
module sdram_frontend_chk (
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [11:0] addr,
    input logic [1:0]  dqm,
    input logic [2:0]  cmd_o,
    input logic [1:0]  bank_o,
    input logic        auto_pre_o,
    input logic [1:0]  wr_be_o,
    input logic [1:0]  rd_oe_o,
    input logic        err_o,
    input logic [3:0]  bank_open_o,
    input logic        sref_o,
    input logic        suspend_o
);
    assert_cs_high_nop_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> cmd_o == 3'd0);

    assert_miss_keeps_banks_R4: assert property (@(posedge clk) disable iff (rst)
        err_o |-> bank_open_o == $past(bank_open_o));

    assert_autopre_closes_R5: assert property (@(posedge clk) disable iff (rst)
        auto_pre_o |-> !bank_open_o[bank_o]);

    assert_pre_all_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n && addr[10] && !sref_o && !suspend_o)
        |=> bank_open_o == 4'b0000);

    assert_wr_be_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_be_o != 2'b00) |-> cmd_o == 3'd3);

    assert_rd_mask_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2)) |-> rd_oe_o == ~$past(dqm, 2));

    assert_suspend_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        suspend_o |=> cmd_o == 3'd0);

    assert_sref_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (sref_o && !cke) |=> sref_o);
endmodule

bind sdram_frontend sdram_frontend_chk u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .dqm(dqm), .cmd_o(cmd_o), .bank_o(bank_o),
    .auto_pre_o(auto_pre_o), .wr_be_o(wr_be_o), .rd_oe_o(rd_oe_o), .err_o(err_o),
    .bank_open_o(bank_open_o), .sref_o(sref_o), .suspend_o(suspend_o)
);

// File: tb/tb_sdram_frontend.sv
`timescale 1ns/1ps
module tb_sdram_frontend;
    logic clk = 0, rst = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
    logic [11:0] addr = '0;
    logic [1:0]  ba = '0, dqm = '0;
    logic [2:0]  cmd_o;
    logic [1:0]  bank_o, wr_be_o, rd_oe_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o, err_o, sref_o, suspend_o;
    logic [3:0]  bank_open_o;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    sdram_frontend dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba(ba), .dqm(dqm), .cmd_o(cmd_o), .bank_o(bank_o),
        .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o), .wr_be_o(wr_be_o),
        .rd_oe_o(rd_oe_o), .err_o(err_o), .bank_open_o(bank_open_o), .sref_o(sref_o),
        .suspend_o(suspend_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic r, input logic ca, input logic w,
                        input logic [11:0] a, input logic [1:0] b,
                        input logic [1:0] m, input logic k);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = a; ba = b; dqm = m; cke = k;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                         step(0,1,1,1,12'h0,2'd0,2'b00,1); endtask
    task automatic act(input logic [1:0] b, input logic [11:0] row); step(0,0,1,1,row,b,2'b00,1); endtask
    task automatic rd(input logic [1:0] b, input logic [11:0] a);    step(0,1,0,1,a,b,2'b00,1); endtask
    task automatic wr(input logic [1:0] b, input logic [11:0] a, input logic [1:0] m); step(0,1,0,0,a,b,m,1); endtask
    task automatic pre(input logic [1:0] b, input logic all);        step(0,0,1,0,{1'b0,all,10'h0},b,2'b00,1); endtask

    function automatic int exp_code(input logic [2:0] v, input logic k);
        if (v == 3'b011) return 1;
        if (v == 3'b101) return 2;
        if (v == 3'b100) return 3;
        if (v == 3'b010) return 4;
        if (v == 3'b001) return k ? 5 : 6;
        return 0;
    endfunction

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [1:0] hist [0:15];
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R11 reset state
        chk("R11 cmd", cmd_o, 0);
        chk("R11 banks", bank_open_o, 0);
        chk("R11 rd_oe", rd_oe_o, 0);
        chk("R11 sref/suspend", {sref_o, suspend_o}, 0);
        chk("R11 err/ap/wbe", {err_o, auto_pre_o, wr_be_o}, 0);

        // R1 sweep with chip select high
        act(2'd0, 12'h005);
        for (int v = 0; v < 8; v++) begin
            step(1, v[2], v[1], v[0], 12'h400, 2'd0, 2'b00, 1);
            chk("R1 cmd", cmd_o, 0);
            chk("R1 bank0 still open", bank_open_o, 4'b0001);
        end

        // R2 full strobe sweep, cke high
        for (int v = 0; v < 8; v++) begin
            act(2'd0, 12'h005);
            step(0, v[2], v[1], v[0], 12'h000, 2'd0, 2'b00, 1);
            chk("R2 decode", cmd_o, exp_code(v[2:0], 1'b1));
        end
        pre(2'd0, 1'b1);

        // R3 activate and access each bank
        for (int b = 0; b < 4; b++) begin
            act(b[1:0], 12'h0A5 + 12'(b * 12'h111));
            chk("R3 act row", row_o, 12'h0A5 + b * 12'h111);
        end
        chk("R3 all open", bank_open_o, 4'hF);
        for (int b = 0; b < 4; b++) begin
            rd(b[1:0], 12'(b * 37 + 300));
            chk("R3 rd cmd", cmd_o, 2);
            chk("R3 rd row", row_o, 12'h0A5 + b * 12'h111);
            chk("R3 rd bank", bank_o, b);
            chk("R3 rd col", col_o, (b * 37 + 300) & 9'h1FF);
        end

        // R6 single-bank then all-bank precharge
        pre(2'd2, 1'b0);
        chk("R6 one bank", bank_open_o, 4'b1011);
        pre(2'd0, 1'b1);
        chk("R6 all banks", bank_open_o, 4'b0000);

        // R4 access to closed bank
        rd(2'd2, 12'h010);
        chk("R4 err", err_o, 1);
        chk("R4 cmd nop", cmd_o, 0);
        chk("R4 banks", bank_open_o, 0);
        nop();
        chk("R4 err pulse", err_o, 0);

        // R5 auto-precharge on write and read
        act(2'd1, 12'h0F0);
        wr(2'd1, 12'h412, 2'b00);
        chk("R5 ap", auto_pre_o, 1);
        chk("R5 cmd", cmd_o, 3);
        chk("R5 closed", bank_open_o, 0);
        act(2'd3, 12'h0F1);
        rd(2'd3, 12'h003);
        chk("R5 no ap", {auto_pre_o, bank_open_o}, 5'b0_1000);

        // R7 write mask sweep plus non-write
        for (int m = 0; m < 4; m++) begin
            wr(2'd3, 12'h020, m[1:0]);
            chk("R7 wr_be", wr_be_o, ~m & 3);
        end
        step(0,1,0,1,12'h020,2'd3,2'b00,1);
        chk("R7 read gives 0", wr_be_o, 0);

        // R8 read mask latency sweep
        for (int i = 0; i < 12; i++) begin
            hist[i] = 2'((i * 3) ^ (i >> 1));
            step(0,1,1,1,12'h0,2'd0,hist[i],1);
            if (i >= 1) chk("R8 rd_oe", rd_oe_o, ~hist[i-1] & 3);
        end

        // R9 clock suspension
        step(0,1,1,1,12'h0,2'd0,2'b00,0);
        chk("R9 suspend", suspend_o, 1);
        act(2'd2, 12'h077);
        chk("R9 ignored cmd", cmd_o, 0);
        chk("R9 ignored bank", bank_open_o[2], 0);
        chk("R9 resumed flag", suspend_o, 0);
        act(2'd2, 12'h077);
        chk("R9 accepted", {cmd_o, bank_open_o[2]}, {3'd1, 1'b1});

        // R10 self-refresh
        pre(2'd0, 1'b1);
        step(0,0,0,1,12'h0,2'd0,2'b00,0);
        chk("R10 entry cmd", cmd_o, 6);
        chk("R10 sref", sref_o, 1);
        for (int i = 0; i < 3; i++) begin
            step(0,0,1,1,12'h055,2'd1,2'b00,0);
            chk("R10 held", {sref_o, cmd_o}, {1'b1, 3'd0});
            chk("R10 bank closed", bank_open_o, 0);
        end
        step(0,0,1,1,12'h055,2'd1,2'b00,1);
        chk("R10 exit", {sref_o, cmd_o}, {1'b0, 3'd0});
        chk("R10 exit bank closed", bank_open_o, 0);
        act(2'd1, 12'h055);
        chk("R10 after exit", {cmd_o, bank_open_o}, {3'd1, 4'b0010});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule